// File: doc/BRIEF.md
# Program/Erase Suspend Sequencer

This block is the top-level sequencer for program and erase operations on a block-organised flash array. Commands arrive on a small opcode bus with a target block index. The block starts a program or an erase on an abstract timing engine and pauses it when a suspend is requested. It remembers which kind of operation was parked and on which block, and continues it on resume. The engine's cell-level timing is outside the block. It is reached through four handshake signals: start, pause, continue and pause acknowledge, plus done and fail.

Suspension is nested, and the two kinds are not treated alike. While an erase is parked, reads and programs may target any block other than the erased one. A program started in that window may itself be suspended. While a program is parked, only reads to other blocks are allowed. A resume always continues the program before the erase. Illegal requests are refused and raise a sticky sequence-error flag.

Top module: `pes_seq`

## Requirements
- R1: After reset, the status bus reads 6'b000001 (ready only), and start, continue, pause and read-grant are all low.
- R2: When ready, a program (opcode 1) or an erase (opcode 2) produces a one-cycle `eng_start_o` on the next clock. The operation kind appears on `eng_kind_o` (0 program, 1 erase) and the block on `eng_blk_o`. Ready (status bit 0) drops at the same time.
- R3: While an operation runs, `eng_done_i` returns ready on the next clock. If `eng_fail_i` is high with it, status bit 3 is set for a program or status bit 4 for an erase.
- R4: A suspend (opcode 3) during a running operation raises `eng_pause_o` and holds it until `eng_pause_ack_i`. The suspended bit and ready appear on the SUSP_LAT-th clock edge, counting the acknowledge edge as the first. The suspended bit is status bit 1 for an erase and status bit 2 for a program.
- R5: A suspend issued while no operation runs has no effect: pause stays low and the status is unchanged.
- R6: While an erase is suspended, reads (opcode 5) and programs to other blocks are accepted. A read or program to the suspended block is refused and sets sequence error (status bit 5).
- R7: While a program is suspended, a read to another block gives a one-cycle `rd_ok_o`. A read to the suspended block, or any program, is refused and sets sequence error.
- R8: A program started during an erase suspend may itself be suspended. Resume (opcode 4) first continues the suspended program, and then the suspended erase. Each continue is a one-cycle `eng_cont_o` carrying the parked kind and block.
- R9: A program, erase, read or resume issued while an operation runs or a suspend is settling is refused, sets sequence error and does not disturb the operation.
- R10: Error bits 3, 4 and 5 stay set until a clear command (opcode 6).
- R11: An erase requested while any operation is suspended is refused with sequence error.
- R12: If `eng_done_i` arrives before the pause is acknowledged, the operation completes normally and nothing is marked suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_op_i | input | 3 | Command opcode, 0 = none |
| cmd_blk_i | input | BLK_W | Target block of the command |
| eng_pause_ack_i | input | 1 | Engine has reached a pause point |
| eng_done_i | input | 1 | Engine finished the current operation |
| eng_fail_i | input | 1 | Qualifies done as failed |
| eng_start_o | output | 1 | One-cycle start of a new operation |
| eng_cont_o | output | 1 | One-cycle continue of a parked operation |
| eng_pause_o | output | 1 | Pause request, held until acknowledge |
| eng_kind_o | output | 1 | Current operation kind, 0 program, 1 erase |
| eng_blk_o | output | BLK_W | Current operation block |
| rd_ok_o | output | 1 | One-cycle grant of an accepted read |
| status_o | output | 6 | {seq err, erase err, prog err, prog susp, erase susp, ready} |

## Verification
A corrupted parked-context register would show at the ports one clock after the next resume, as a wrong kind or block on `eng_cont_o`. It would show earlier if a read or program to the parked block is granted when it should raise sequence error. A wrong settle count shifts the rise of a suspended bit against the acknowledge edge, and a per-cycle comparison with the bench's model catches it on that edge. Lost stickiness of an error bit shows as a fall without a preceding clear command.

// File: rtl/pes_pkg.sv
package pes_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_PROG   = 3'd1,
    CMD_ERASE  = 3'd2,
    CMD_SUSP   = 3'd3,
    CMD_RESUME = 3'd4,
    CMD_READ   = 3'd5,
    CMD_CLEAR  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_BUSY   = 2'd1,
    SQ_PAUSE  = 2'd2,
    SQ_SETTLE = 2'd3
  } seq_st_e;

  // operation kind, also the index of its parked-context slot
  localparam int KIND_PROG  = 0;
  localparam int KIND_ERASE = 1;
  localparam int NUM_KINDS  = 2;

  // status bit positions
  localparam int SB_READY = 0;
  localparam int SB_ESUSP = 1;
  localparam int SB_PSUSP = 2;
  localparam int SB_PERR  = 3;
  localparam int SB_EERR  = 4;
  localparam int SB_SERR  = 5;
  localparam int SB_W     = 6;
endpackage

// File: rtl/pes_slot.sv
module pes_slot #(
  parameter int BLK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             vld_o,
  output logic [BLK_W-1:0] blk_o
);
  logic             vld_d;
  logic             blk_en;

  assign blk_en = set_i;

  always_comb begin
    vld_d = vld_o;
    if (clr_i) vld_d = 1'b0;
    if (set_i) vld_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      blk_o <= '0;
    end else begin
      vld_o <= vld_d;
      if (blk_en) blk_o <= blk_i;
    end
  end
endmodule

// File: rtl/pes_settle.sv
module pes_settle #(
  parameter int LAT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expire_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en   = load_i || (cnt_q != '0);
  assign expire_o = (cnt_q == CW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = CW'(LAT - 1);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pes_guard.sv
module pes_guard
  import pes_pkg::*;
#(
  parameter int BLK_W = 8
) (
  input  logic                            idle_i,
  input  logic [2:0]                      op_i,
  input  logic [BLK_W-1:0]                blk_i,
  input  logic [NUM_KINDS-1:0]            park_vld_i,
  input  logic [NUM_KINDS-1:0][BLK_W-1:0] park_blk_i,
  output logic                            go_prog_o,
  output logic                            go_erase_o,
  output logic                            go_read_o,
  output logic                            go_resume_o,
  output logic                            seq_err_o
);
  logic hit_prog, hit_erase;

  assign hit_prog  = park_vld_i[KIND_PROG]  && (blk_i == park_blk_i[KIND_PROG]);
  assign hit_erase = park_vld_i[KIND_ERASE] && (blk_i == park_blk_i[KIND_ERASE]);

  always_comb begin
    go_prog_o   = 1'b0;
    go_erase_o  = 1'b0;
    go_read_o   = 1'b0;
    go_resume_o = 1'b0;
    seq_err_o   = 1'b0;
    case (cmd_e'(op_i))
      CMD_PROG: begin
        if (!idle_i || park_vld_i[KIND_PROG] || hit_erase) seq_err_o = 1'b1;
        else                                               go_prog_o = 1'b1;
      end
      CMD_ERASE: begin
        if (!idle_i || (park_vld_i != '0)) seq_err_o  = 1'b1;
        else                               go_erase_o = 1'b1;
      end
      CMD_READ: begin
        if (!idle_i || hit_prog || hit_erase) seq_err_o = 1'b1;
        else                                  go_read_o = 1'b1;
      end
      CMD_RESUME: begin
        if (!idle_i)                 seq_err_o   = 1'b1;
        else if (park_vld_i != '0)   go_resume_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pes_seq.sv
module pes_seq
  import pes_pkg::*;
#(
  parameter int BLK_COUNT = 135,
  parameter int SUSP_LAT  = 4,
  parameter int BLK_W     = $clog2(BLK_COUNT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cmd_op_i,
  input  logic [BLK_W-1:0] cmd_blk_i,
  input  logic             eng_pause_ack_i,
  input  logic             eng_done_i,
  input  logic             eng_fail_i,
  output logic             eng_start_o,
  output logic             eng_cont_o,
  output logic             eng_pause_o,
  output logic             eng_kind_o,
  output logic [BLK_W-1:0] eng_blk_o,
  output logic             rd_ok_o,
  output logic [5:0]       status_o
);
  seq_st_e                       state_q, state_d;
  logic                          kind_q, kind_d;
  logic [BLK_W-1:0]              blk_q, blk_d;
  logic                          perr_q, perr_d, eerr_q, eerr_d, serr_q, serr_d;
  logic                          start_d, cont_d, rdok_d;
  logic                          start_q, cont_q, rdok_q;
  logic                          settle_load, settle_exp;
  logic [NUM_KINDS-1:0]          slot_set, slot_clr, slot_vld;
  logic [NUM_KINDS-1:0][BLK_W-1:0] slot_blk;
  logic                          go_prog, go_erase, go_read, go_resume, seq_err;
  logic                          clr_err, is_idle;

  assign is_idle = (state_q == SQ_IDLE);
  assign clr_err = (cmd_op_i == CMD_CLEAR);

  pes_guard #(.BLK_W(BLK_W)) u_guard (
    .idle_i      (is_idle),
    .op_i        (cmd_op_i),
    .blk_i       (cmd_blk_i),
    .park_vld_i  (slot_vld),
    .park_blk_i  (slot_blk),
    .go_prog_o   (go_prog),
    .go_erase_o  (go_erase),
    .go_read_o   (go_read),
    .go_resume_o (go_resume),
    .seq_err_o   (seq_err)
  );

  pes_settle #(.LAT(SUSP_LAT)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (settle_load),
    .expire_o (settle_exp)
  );

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_park
    pes_slot #(.BLK_W(BLK_W)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (slot_set[g]),
      .clr_i  (slot_clr[g]),
      .blk_i  (blk_q),
      .vld_o  (slot_vld[g]),
      .blk_o  (slot_blk[g])
    );
  end

  always_comb begin
    state_d     = state_q;
    kind_d      = kind_q;
    blk_d       = blk_q;
    start_d     = 1'b0;
    cont_d      = 1'b0;
    rdok_d      = go_read;
    settle_load = 1'b0;
    slot_set    = '0;
    slot_clr    = '0;
    perr_d      = perr_q & ~clr_err;
    eerr_d      = eerr_q & ~clr_err;
    serr_d      = (serr_q & ~clr_err) | seq_err;
    case (state_q)
      SQ_IDLE: begin
        if (go_prog || go_erase) begin
          start_d = 1'b1;
          kind_d  = go_erase;
          blk_d   = cmd_blk_i;
          state_d = SQ_BUSY;
        end else if (go_resume) begin
          cont_d  = 1'b1;
          state_d = SQ_BUSY;
          if (slot_vld[KIND_PROG]) begin
            kind_d             = 1'b0;
            blk_d              = slot_blk[KIND_PROG];
            slot_clr[KIND_PROG] = 1'b1;
          end else begin
            kind_d              = 1'b1;
            blk_d               = slot_blk[KIND_ERASE];
            slot_clr[KIND_ERASE] = 1'b1;
          end
        end
      end
      SQ_BUSY, SQ_PAUSE: begin
        if (eng_done_i) begin
          state_d = SQ_IDLE;
          if (eng_fail_i) begin
            if (kind_q) eerr_d = 1'b1;
            else        perr_d = 1'b1;
          end
        end else if (state_q == SQ_BUSY) begin
          if (cmd_op_i == CMD_SUSP) state_d = SQ_PAUSE;
        end else if (eng_pause_ack_i) begin
          settle_load = 1'b1;
          state_d     = SQ_SETTLE;
        end
      end
      SQ_SETTLE: begin
        if (settle_exp) begin
          state_d          = SQ_IDLE;
          slot_set[kind_q] = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      kind_q  <= 1'b0;
      blk_q   <= '0;
      perr_q  <= 1'b0;
      eerr_q  <= 1'b0;
      serr_q  <= 1'b0;
      start_q <= 1'b0;
      cont_q  <= 1'b0;
      rdok_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      blk_q   <= blk_d;
      perr_q  <= perr_d;
      eerr_q  <= eerr_d;
      serr_q  <= serr_d;
      start_q <= start_d;
      cont_q  <= cont_d;
      rdok_q  <= rdok_d;
    end
  end

  assign eng_start_o = start_q;
  assign eng_cont_o  = cont_q;
  assign rd_ok_o     = rdok_q;
  assign eng_pause_o = (state_q == SQ_PAUSE);
  assign eng_kind_o  = kind_q;
  assign eng_blk_o   = blk_q;

  always_comb begin
    status_o           = '0;
    status_o[SB_READY] = is_idle;
    status_o[SB_ESUSP] = slot_vld[KIND_ERASE];
    status_o[SB_PSUSP] = slot_vld[KIND_PROG];
    status_o[SB_PERR]  = perr_q;
    status_o[SB_EERR]  = eerr_q;
    status_o[SB_SERR]  = serr_q;
  end
endmodule

// File: rtl/pes_seq_chk.sv
module pes_seq_chk #(
  parameter int SUSP_LAT = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] cmd_op_i,
  input logic       eng_pause_ack_i,
  input logic       eng_done_i,
  input logic       eng_start_o,
  input logic       eng_cont_o,
  input logic       eng_pause_o,
  input logic       eng_kind_o,
  input logic       rd_ok_o,
  input logic [5:0] status_o
);
  logic [7:0] lat_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           lat_cnt <= 8'd0;
    else if (eng_pause_o && eng_pause_ack_i && !eng_done_i) lat_cnt <= 8'd1;
    else if (lat_cnt != 8'd0 && lat_cnt != 8'hff)          lat_cnt <= lat_cnt + 8'd1;
  end

  AST_START_FROM_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> $past(status_o[0])); // R2

  AST_PAUSE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_pause_o && !eng_pause_ack_i && !eng_done_i |=> eng_pause_o); // R4

  AST_SUSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_o[1]) || $rose(status_o[2])) |-> lat_cnt == 8'(SUSP_LAT)); // R4

  AST_IDLE_SUSPEND_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && cmd_op_i == 3'd3 |=> !eng_pause_o && status_o[0]); // R5

  AST_NO_START_PROG_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |-> !eng_start_o); // R7

  AST_RESUME_PROG_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_cont_o && $past(status_o[2]) |-> !eng_kind_o); // R8

  AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({eng_start_o, eng_cont_o, rd_ok_o})); // R8

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(status_o[3]) || $fell(status_o[4]) || $fell(status_o[5])) |->
      $past(cmd_op_i) == 3'd6); // R10
endmodule

bind pes_seq pes_seq_chk #(.SUSP_LAT(SUSP_LAT)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_op_i        (cmd_op_i),
  .eng_pause_ack_i (eng_pause_ack_i),
  .eng_done_i      (eng_done_i),
  .eng_start_o     (eng_start_o),
  .eng_cont_o      (eng_cont_o),
  .eng_pause_o     (eng_pause_o),
  .eng_kind_o      (eng_kind_o),
  .rd_ok_o         (rd_ok_o),
  .status_o        (status_o)
);

// File: tb/pes_seq_bench.sv
module pes_seq_bench;
  localparam int BW  = 8;
  localparam int LAT = 4;

  logic          clk, rst_n;
  logic [2:0]    op;
  logic [BW-1:0] blk;
  logic          ack, done, fail;
  logic          start, cont, pause, kind, rdok;
  logic [BW-1:0] eblk;
  logic [5:0]    status;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  string cur_req = "R1";

  pes_seq #(.BLK_COUNT(135), .SUSP_LAT(LAT)) u_pes_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_op_i(op), .cmd_blk_i(blk),
    .eng_pause_ack_i(ack), .eng_done_i(done), .eng_fail_i(fail),
    .eng_start_o(start), .eng_cont_o(cont), .eng_pause_o(pause),
    .eng_kind_o(kind), .eng_blk_o(eblk), .rd_ok_o(rdok), .status_o(status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference: 0 idle, 1 running, 2 pausing, 3 settling
  int       m_state, m_cnt, m_kind, m_blk;
  bit       m_vld[2];
  int       m_pb[2];
  bit       m_perr, m_eerr, m_serr, m_start, m_cont, m_rdok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_kind = 0; m_blk = 0;
      m_vld[0] = 0; m_vld[1] = 0; m_pb[0] = 0; m_pb[1] = 0;
      m_perr = 0; m_eerr = 0; m_serr = 0;
      m_start = 0; m_cont = 0; m_rdok = 0;
    end else begin
      int  o, b;
      bit  he, hp;
      o = op; b = blk;
      hp = m_vld[0] && (b == m_pb[0]);
      he = m_vld[1] && (b == m_pb[1]);
      m_start = 0; m_cont = 0; m_rdok = 0;
      if (o == 6) begin m_perr = 0; m_eerr = 0; m_serr = 0; end
      if (m_state != 0 && (o == 1 || o == 2 || o == 4 || o == 5)) m_serr = 1;
      if (m_state == 0) begin
        if (o == 1) begin
          if (m_vld[0] || he) m_serr = 1;
          else begin m_start = 1; m_kind = 0; m_blk = b; m_state = 1; end
        end else if (o == 2) begin
          if (m_vld[0] || m_vld[1]) m_serr = 1;
          else begin m_start = 1; m_kind = 1; m_blk = b; m_state = 1; end
        end else if (o == 5) begin
          if (he || hp) m_serr = 1; else m_rdok = 1;
        end else if (o == 4) begin
          if (m_vld[0]) begin
            m_cont = 1; m_kind = 0; m_blk = m_pb[0]; m_vld[0] = 0; m_state = 1;
          end else if (m_vld[1]) begin
            m_cont = 1; m_kind = 1; m_blk = m_pb[1]; m_vld[1] = 0; m_state = 1;
          end
        end
      end else if (m_state == 1 || m_state == 2) begin
        if (done) begin
          if (fail) begin if (m_kind == 1) m_eerr = 1; else m_perr = 1; end
          m_state = 0;
        end else if (m_state == 1) begin
          if (o == 3) m_state = 2;
        end else if (ack) begin
          m_state = 3; m_cnt = 1;
        end
      end else begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_state = 0; m_vld[m_kind] = 1; m_pb[m_kind] = m_blk;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  function automatic int model_status();
    return {26'd0, m_serr, m_eerr, m_perr, m_vld[0], m_vld[1], (m_state == 0)};
  endfunction

  // compare on every falling edge after reset
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "status", int'(status), model_status());
      chk(cur_req, "start", int'(start), int'(m_start));
      chk(cur_req, "cont", int'(cont), int'(m_cont));
      chk(cur_req, "rd_ok", int'(rdok), int'(m_rdok));
      chk(cur_req, "pause", int'(pause), int'(m_state == 2));
      chk(cur_req, "kind", int'(kind), m_kind);
      chk(cur_req, "blk", int'(eblk), m_blk);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cmd(input int o, input int b);
    @(negedge clk); op = 3'(o); blk = BW'(b);
    @(negedge clk); op = 3'd0;
  endtask

  task automatic pulse_done(input bit f);
    @(negedge clk); done = 1'b1; fail = f;
    @(negedge clk); done = 1'b0; fail = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic suspend_and_park();
    cmd(3, 0); idle(2); pulse_ack(); idle(LAT + 2);
  endtask

  initial begin
    rst_n = 1'b0; op = 3'd0; blk = '0; ack = 1'b0; done = 1'b0; fail = 1'b0;
    #1;
    cur_req = "R1";
    chk("R1", "reset status", int'(status), 1);
    chk("R1", "reset pulses", int'({start, cont, pause, rdok}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    cur_req = "R2"; cmd(1, 5); idle(2);
    cur_req = "R3"; pulse_done(1'b0); idle(1);
    cur_req = "R2"; cmd(2, 7); idle(2);
    cur_req = "R3"; pulse_done(1'b1); idle(1);
    chk("R3", "erase fail bit", int'(status[4]), 1);
    cur_req = "R10"; idle(3);
    chk("R10", "erase err held", int'(status[4]), 1);
    cmd(6, 0); idle(1);
    chk("R10", "cleared", int'(status), 1);

    cur_req = "R9"; cmd(1, 2); cmd(5, 9); cmd(4, 0); idle(1);
    chk("R9", "seq err while busy", int'(status[5]), 1);
    pulse_done(1'b0); cmd(6, 0);

    cur_req = "R5"; cmd(3, 0); idle(3);
    chk("R5", "idle suspend", int'(status), 1);

    cur_req = "R4"; cmd(2, 10); suspend_and_park();
    chk("R4", "erase parked", int'(status), 3);
    cur_req = "R6"; cmd(5, 10); cmd(1, 10); idle(1);
    chk("R6", "access to parked erase", int'(status[5]), 1);
    cmd(6, 0); cmd(5, 3); idle(1);
    cur_req = "R11"; cmd(2, 3); idle(1);
    chk("R11", "erase while parked", int'(status[5]), 1);
    cmd(6, 0);

    cur_req = "R6"; cmd(1, 3); idle(2);
    cur_req = "R8"; suspend_and_park();
    chk("R8", "nested parked", int'(status), 7);
    cur_req = "R7"; cmd(5, 3); cmd(5, 4); cmd(1, 4); idle(1);
    chk("R7", "prog parked refusals", int'(status[5]), 1);
    cmd(6, 0);

    cur_req = "R8"; cmd(4, 0); idle(1);
    chk("R8", "resume prog kind", int'(kind), 0);
    chk("R8", "resume prog blk", int'(eblk), 3);
    pulse_done(1'b0); cmd(4, 0); idle(1);
    chk("R8", "resume erase blk", int'(eblk), 10);
    pulse_done(1'b0); idle(2);

    cur_req = "R12"; cmd(1, 1); cmd(3, 0); idle(1); pulse_done(1'b0); idle(LAT + 2);
    chk("R12", "done beats ack", int'(status), 1);

    cur_req = "R3"; cmd(1, 6); idle(1); pulse_done(1'b1); idle(2);
    chk("R3", "prog fail bit", int'(status[3]), 1);
    cmd(6, 0); idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule